// File: doc/BRIEF.md
# Vertical Video Window Gate

This block decides, line by line, whether the current display line falls inside a programmable vertical video window. A line counter restarts on each rising edge of vertical sync and advances once per line strobe from the display timing generator. The window limits are therefore measured from the sync edge and not from the first visible line. Software applies the frame offset itself: the start line is the wanted screen line plus (total lines − sync end line) + 1, and the end line uses the same sum plus 2.

Two 64-bit registers sit behind a simple read/write port. The position register holds the start and end lines. The scale register holds a scale configuration field and a read-only overrun flag. The flag is set when the display begins consuming a line before the next line-buffer fill has started, and a read of the register clears it. Writes to the position register are held in a shadow copy. The shadow is transferred to the comparator only on the next vertical sync, so the window never moves in the middle of a frame.

Top module: `vwin_gate`

## Requirements
- R1: The position register (reg_sel = 0) holds the start line in bits 10:0 and the end line in bits 26:16. Bits 15:11 and 63:27 read as zero, and writes to them are ignored. A read returns the last written values, even if no vertical sync has occurred since the write.
- R2: After reset both registers read as zero, and win_active, overrun and scale_cfg are low.
- R3: The line counter becomes 0 on the clock edge at which vsync is first seen high after being low. It increments by one for each cycle in which line_stb is high. Holding vsync high does not restart the counter again.
- R4: The line counter saturates at 2047 and does not wrap.
- R5: win_active is high exactly when start ≤ line counter < end, using the limits in force for the current frame.
- R6: When end ≤ start, win_active stays low on every line.
- R7: A write to the position register takes effect for the window only at the next rising edge of vsync.
- R8: A cycle with disp_start high sets the overrun flag when fill_start has not been high since the previous disp_start and is not high in that same cycle. Right after reset, fill_start counts as having occurred. The flag appears on the overrun port and in bit 31 of the scale register.
- R9: The overrun flag is sticky. A read of the scale register (reg_sel = 1) returns the flag as it was before the read, and clears it at the end of that cycle.
- R10: When a set event and a clearing read of the scale register fall in the same cycle, the flag stays set.
- R11: Bits 13:0 of the scale register are read/write and drive scale_cfg. All other scale bits except bit 31 read as zero. Writes to bit 31 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | Vertical sync level from the timing generator |
| line_stb | input | 1 | One-cycle strobe at each line start |
| fill_start | input | 1 | Strobe: a line-buffer fill has begun |
| disp_start | input | 1 | Strobe: the display begins consuming a line |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable (a scale read clears the flag) |
| reg_sel | input | 1 | 0 = position register, 1 = scale register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational from reg_sel |
| win_active | output | 1 | Current line lies inside the window |
| overrun | output | 1 | Sticky overrun flag |
| scale_cfg | output | 14 | Scale configuration field |

## Verification
The overrun flag can be set by a late disp_start and cleared by a software read of the scale register in the same clock cycle. The bench first forces the flag high. It then raises disp_start with no pending fill together with a scale read, in one cycle. The returned data must show the flag still set from before the read. The flag must remain high after the edge, and it may fall only on a later read that has no coinciding set event.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  localparam int LINE_W    = 11;
  localparam int DATA_W    = 64;
  localparam int START_LSB = 0;
  localparam int END_LSB   = 16;
  localparam int SCALE_W   = 14;
  localparam int FLAG_BIT  = 31;

  typedef logic [LINE_W-1:0] line_t;

  // Window membership: half-open interval [lo, hi)
  function automatic logic line_in_window(input line_t lo, input line_t hi, input line_t ln);
    return (ln >= lo) && (ln < hi);
  endfunction

  // Saturating increment of a line number
  function automatic line_t line_step(input line_t ln);
    return (ln == '1) ? ln : ln + 1'b1;
  endfunction
endpackage

// File: rtl/vwin_line_ctr.sv
module vwin_line_ctr
  import vwin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vs_rise,
  input  logic  line_stb,
  output line_t line_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        line_q <= '0;
    else if (vs_rise)  line_q <= '0;
    else if (line_stb) line_q <= line_step(line_q);
  end

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_q == '0));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !vs_rise && line_q != '1) |=> (line_q == $past(line_q) + 1'b1));
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q == '1 && !vs_rise) |=> (line_q == '1));
endmodule

// File: rtl/vwin_regs.sv
module vwin_regs
  import vwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs_rise,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              flag,
  output logic [DATA_W-1:0] reg_rdata,
  output line_t             act_start,
  output line_t             act_end,
  output logic [SCALE_W-1:0] scale_q,
  output logic              rd_scale
);
  line_t sh_start, sh_end;
  logic  wr_pos, wr_scale;

  assign wr_pos   = reg_wr && !reg_sel;
  assign wr_scale = reg_wr &&  reg_sel;
  assign rd_scale = reg_rd &&  reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_start <= '0;
      sh_end   <= '0;
      scale_q  <= '0;
    end else begin
      if (wr_pos) begin
        sh_start <= reg_wdata[START_LSB +: LINE_W];
        sh_end   <= reg_wdata[END_LSB   +: LINE_W];
      end
      if (wr_scale) scale_q <= reg_wdata[SCALE_W-1:0];
    end
  end

  // Frame-aligned copy used by the comparator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_start <= '0;
      act_end   <= '0;
    end else if (vs_rise) begin
      act_start <= sh_start;
      act_end   <= sh_end;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_sel) begin
      reg_rdata[START_LSB +: LINE_W] = sh_start;
      reg_rdata[END_LSB   +: LINE_W] = sh_end;
    end else begin
      reg_rdata[SCALE_W-1:0] = scale_q;
      reg_rdata[FLAG_BIT]    = flag;
    end
  end

  assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> ($stable(act_start) && $stable(act_end)));
  assert_pos_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[DATA_W-1:END_LSB+LINE_W] == '0 &&
                  reg_rdata[END_LSB-1:START_LSB+LINE_W] == '0));
  assert_scale_rsvd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[DATA_W-1:FLAG_BIT+1] == '0 &&
                 reg_rdata[FLAG_BIT-1:SCALE_W] == '0));
endmodule

// File: rtl/vwin_overrun.sv
module vwin_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_start,
  input  logic disp_start,
  input  logic rd_clr,
  output logic flag,
  output logic set_ev
);
  logic fill_seen;

  assign set_ev = disp_start && !fill_seen && !fill_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill_seen <= 1'b1;
    else if (disp_start) fill_seen <= 1'b0;
    else if (fill_start) fill_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (rd_clr) flag <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_ev) |=> !flag);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rd_clr) |=> flag);
endmodule

// File: rtl/vwin_gate.sv
module vwin_gate
  import vwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic               line_stb,
  input  logic               fill_start,
  input  logic               disp_start,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               win_active,
  output logic               overrun,
  output logic [SCALE_W-1:0] scale_cfg
);
  logic  vsync_q, vs_rise, rd_scale, set_ev;
  line_t line_q, act_start, act_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsync_q <= 1'b0;
    else        vsync_q <= vsync;
  end
  assign vs_rise = vsync && !vsync_q;

  vwin_line_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .line_stb(line_stb), .line_q(line_q)
  );

  vwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flag(overrun), .reg_rdata(reg_rdata),
    .act_start(act_start), .act_end(act_end), .scale_q(scale_cfg), .rd_scale(rd_scale)
  );

  vwin_overrun u_ovr (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .disp_start(disp_start),
    .rd_clr(rd_scale), .flag(overrun), .set_ev(set_ev)
  );

  assign win_active = line_in_window(act_start, act_end, line_q);

  assert_empty_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_end <= act_start) |-> !win_active);
  assert_below_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q < act_start) |-> !win_active);
endmodule

// File: tb/vwin_gate_bench.sv
module vwin_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0, line_stb = 1'b0, fill_start = 1'b0, disp_start = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        win_active, overrun;
  logic [13:0] scale_cfg;
  int          n_chk = 0, n_fail = 0;
  logic [63:0] rd;

  always #10 clk = ~clk;

  vwin_gate u_vwin_gate (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .line_stb(line_stb),
    .fill_start(fill_start), .disp_start(disp_start), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .win_active(win_active), .overrun(overrun),
    .scale_cfg(scale_cfg)
  );

  // {start, end, lines after sync, expected win_active}
  localparam int NV = 9;
  localparam logic [33:0] VEC [NV] = '{
    {11'd10,   11'd20,   11'd9,    1'b0},
    {11'd10,   11'd20,   11'd10,   1'b1},
    {11'd10,   11'd20,   11'd19,   1'b1},
    {11'd10,   11'd20,   11'd20,   1'b0},
    {11'd0,    11'd1,    11'd0,    1'b1},
    {11'd30,   11'd30,   11'd30,   1'b0},
    {11'd40,   11'd35,   11'd37,   1'b0},
    {11'd40,   11'd35,   11'd41,   1'b0},
    {11'd100,  11'd2000, 11'd1500, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [63:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [63:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic vs_pulse();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_stb = 1'b1;
      @(negedge clk); line_stb = 1'b0;
    end
  endtask

  task automatic disp(input logic with_fill);
    @(negedge clk); disp_start = 1'b1; fill_start = with_fill;
    @(negedge clk); disp_start = 1'b0; fill_start = 1'b0;
  endtask

  function automatic logic [63:0] pos(input int s, input int e);
    return (64'(e) << 16) | 64'(s);
  endfunction

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd_reg(1'b0, rd); chk("R2 pos reset", rd, 64'h0);
    rd_reg(1'b1, rd); chk("R2 scale reset", rd, 64'h0);
    chk("R2 win_active reset", 64'(win_active), 64'h0);
    chk("R2 overrun reset", 64'(overrun), 64'h0);
    chk("R2 scale_cfg reset", 64'(scale_cfg), 64'h0);

    // R5 R6 R3 table walk
    for (int k = 0; k < NV; k++) begin
      wr_reg(1'b0, pos(int'(VEC[k][33:23]), int'(VEC[k][22:12])));
      vs_pulse();
      lines(int'(VEC[k][11:1]));
      chk($sformatf("R5/R6 vector %0d", k), 64'(win_active), 64'(VEC[k][0]));
    end

    // R3: vsync held high restarts once; strobes during high count
    wr_reg(1'b0, pos(3, 4));
    @(negedge clk); vsync = 1'b1;
    lines(3);
    @(negedge clk); vsync = 1'b0;
    chk("R3 no restart while vsync high", 64'(win_active), 64'h1);

    // R1 field layout, reserved bits
    wr_reg(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(1'b0, rd); chk("R1 reserved zero", rd, 64'h0000_0000_07FF_07FF);

    // R7 shadowing
    wr_reg(1'b0, pos(5, 8));
    vs_pulse();
    wr_reg(1'b0, pos(50, 60));
    lines(6);
    chk("R7 old window mid-frame", 64'(win_active), 64'h1);
    rd_reg(1'b0, rd); chk("R1 read shows shadow", rd, pos(50, 60));
    vs_pulse();
    lines(55);
    chk("R7 new window after sync", 64'(win_active), 64'h1);

    // R4 saturation
    wr_reg(1'b0, pos(0, 2047));
    vs_pulse();
    lines(2046);
    chk("R4 line 2046 inside", 64'(win_active), 64'h1);
    lines(20);
    chk("R4 saturated not wrapped", 64'(win_active), 64'h0);

    // R11 scale field
    wr_reg(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(1'b1, rd); chk("R11 scale readback", rd, 64'h3FFF);
    chk("R11 scale_cfg", 64'(scale_cfg), 64'h3FFF);

    // R8 overrun detection
    disp(1'b0);
    chk("R8 first disp after reset no error", 64'(overrun), 64'h0);
    disp(1'b1);
    chk("R8 fill same cycle no error", 64'(overrun), 64'h0);
    @(negedge clk); fill_start = 1'b1;
    @(negedge clk); fill_start = 1'b0;
    disp(1'b0);
    chk("R8 fill before disp no error", 64'(overrun), 64'h0);
    disp(1'b0);
    chk("R8 late fill sets flag", 64'(overrun), 64'h1);

    // R10 set and clearing read together
    @(negedge clk); disp_start = 1'b1; reg_rd = 1'b1; reg_sel = 1'b1;
    #1 rd = reg_rdata;
    @(negedge clk); disp_start = 1'b0; reg_rd = 1'b0;
    chk("R10 read returns pre-read", rd, 64'h8000_3FFF);
    chk("R10 set wins", 64'(overrun), 64'h1);

    // R9 read clears
    rd_reg(1'b1, rd); chk("R9 read returns set flag", rd, 64'h8000_3FFF);
    chk("R9 flag cleared", 64'(overrun), 64'h0);
    rd_reg(1'b1, rd); chk("R9 next read clear", rd, 64'h3FFF);
    wr_reg(1'b1, 64'h8000_0000);
    rd_reg(1'b1, rd); chk("R11 bit31 write ignored", rd, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule